// File: doc/BRIEF.md
# EDO Page-Mode Access Sequencer

This block sits between a host request port and a 16-bit EDO DRAM. It turns host reads and writes into row strobe, two byte-lane column strobes, write-enable and output-enable sequences, and it multiplexes the row and column halves of the host address onto one address bus. When a row is opened, it stays open. Later requests that hit the same row are served with short column cycles. The row is closed on a row miss, when a refresh is requested, or before the row strobe would stay low longer than allowed.

Every timing constraint is a parameter counted in clock cycles: precharge, minimum and maximum row-strobe width, row-to-column delay, column low and high widths, and the refresh setup and hold times. A refresh uses the CAS-before-RAS scheme, with both column strobes falling before the row strobe. The host's two byte enables map one-to-one onto the lower and upper column strobes. All writes are early writes, so the data pins of the memory never drive during a write.

Top module: `edo_page_seq`

## Requirements
- R1: While a row is open, a request whose row field equals the open row is served with a column cycle only: no new falling edge of `dram_ras_no`.
- R2: A request to another row closes the open row and reopens the new one. Every low pulse of `dram_ras_no` lasts at least `T_RAS_MIN` cycles, and every high interval between two low pulses lasts at least `T_RP` cycles.
- R3: `dram_ras_no` is never low for more than `T_RASP_MAX` cycles. An open row with no further traffic is closed after exactly `T_RASP_MAX - (T_CAS + T_CP + 1)` cycles of row strobe low.
- R4: In a write, `dram_we_no` is low at least one cycle before any column strobe falls. `dram_oe_no` is high in every cycle where `dram_we_no` is low.
- R5: `req_be_i[0]` enables `dram_lcas_no`, covering data bits 7:0. `req_be_i[1]` enables `dram_ucas_no`, covering bits 15:8. A disabled byte is not written, and its bits read back as zero in `rsp_rdata_o`.
- R6: A refresh drives both column strobes low for at least `T_CSR` cycles before `dram_ras_no` falls, holds them low at least `T_CHR` cycles after that fall, and keeps `dram_we_no` high. An open row is closed first. `ref_done_o` pulses once at the end of the refresh. A refresh request takes precedence over a host request present in the same cycle.
- R7: The two column strobes never fall in different cycles within one access. Either both fall together, or the disabled lane stays high.
- R8: After reset, all strobes are high, `req_ready_o` is high and `rsp_valid_o` is low.
- R9: Read data is sampled in the last column-low cycle. `rsp_valid_o` is a single-cycle pulse in the first cycle after the column strobe rises.
- R10: `req_addr_i[COL_W-1:0]` is the column and `req_addr_i[ADDR_W-1:COL_W]` is the row. The row is on `dram_addr_o` when `dram_ras_no` falls, and the zero-extended column is on it when a column strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted in this cycle when valid is also high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (22) | Row and column word address |
| req_be_i | input | 2 | Byte enables, bit 0 = bits 7:0 |
| req_wdata_i | input | DQ_W (16) | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DQ_W (16) | Read data, disabled bytes zero |
| ref_req_i | input | 1 | Refresh grant, held until done |
| ref_done_o | output | 1 | Refresh complete pulse |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_ucas_no | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_no | output | 1 | Lower-byte column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | ROW_W (13) | Multiplexed address |
| dram_dq_o | output | DQ_W (16) | Write data to memory |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DQ_W (16) | Read data from memory |

## Verification
A refresh grant and a host request that hits the open row can arrive in the same cycle. The bench raises both on one clock edge while a row is open. Refresh must win. The bench checks that the host request is not accepted before `ref_done_o`, and that the row is closed and a CAS-before-RAS cycle with correct setup and hold runs in between. The host read must then reopen the row with a fresh row-strobe fall and return the previously written data. A memory model in the bench decodes the strobes and supports the other checks, which are made at the pins.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ROWSET,
    S_ACT,
    S_COL,
    S_CAS_LO,
    S_CAS_HI,
    S_OPEN,
    S_PRE,
    S_REF_CSR,
    S_REF_RAS,
    S_REF_HOLD
  } seq_state_e;
endpackage

// File: rtl/edo_wait_timer.sv
module edo_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/edo_ras_age.sv
module edo_ras_age #(
  parameter int LIMIT = 25000,
  parameter int W     = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ras_low_i,
  output logic [W-1:0] age_o
);
  localparam logic [W-1:0] SAT = W'(LIMIT);
  logic [W-1:0] age_q;

  // age = cycles the row strobe has already been low before this one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (!ras_low_i)  age_q <= '0;
    else if (age_q != SAT) age_q <= age_q + 1'b1;
  end

  assign age_o = age_q;
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] req_row_i,
  output logic [ROW_W-1:0] row_o,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      vld_q <= 1'b0;
    end else if (open_i) begin
      row_q <= row_i;
      vld_q <= 1'b1;
    end else if (close_i) begin
      vld_q <= 1'b0;
    end
  end

  assign row_o = row_q;
  assign hit_o = vld_q && (req_row_i == row_q);
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
  import edo_seq_pkg::*;
#(
  parameter int ROW_W      = 13,
  parameter int COL_W      = 9,
  parameter int DQ_W       = 16,
  parameter int TMR_W      = 8,
  parameter int T_RP       = 8,
  parameter int T_RAS_MIN  = 13,
  parameter int T_RCD      = 3,
  parameter int T_CAS      = 2,
  parameter int T_CP       = 2,
  parameter int T_CSR      = 2,
  parameter int T_CHR      = 2,
  parameter int T_RASP_MAX = 25000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_we_i,
  input  logic [ROW_W+COL_W-1:0]  req_addr_i,
  input  logic [1:0]              req_be_i,
  input  logic [DQ_W-1:0]         req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [DQ_W-1:0]         rsp_rdata_o,
  input  logic                    ref_req_i,
  output logic                    ref_done_o,
  output logic                    dram_ras_no,
  output logic                    dram_ucas_no,
  output logic                    dram_lcas_no,
  output logic                    dram_we_no,
  output logic                    dram_oe_no,
  output logic [ROW_W-1:0]        dram_addr_o,
  output logic [DQ_W-1:0]         dram_dq_o,
  output logic                    dram_dq_oe_o,
  input  logic [DQ_W-1:0]         dram_dq_i
);
  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int LANES     = 2;
  localparam int LANE_W    = DQ_W / LANES;
  localparam int AGE_W     = $clog2(T_RASP_MAX + 1);
  localparam int PAGE_LEN  = 1 + T_CAS + T_CP;
  localparam int HIT_LIMIT = T_RASP_MAX - 2 - PAGE_LEN;
  localparam logic [AGE_W-1:0] MIN_AGE = AGE_W'(T_RAS_MIN - 1);
  localparam logic [AGE_W-1:0] HIT_AGE = AGE_W'(HIT_LIMIT);

  seq_state_e state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic [AGE_W-1:0] age_q;
  logic             ras_low, row_hit, open_row, close_row, accept, ref_done;
  logic             timeout, can_close;
  logic [ROW_W-1:0] open_row_q;
  logic             cur_we_q;
  logic [1:0]       cur_be_q;
  logic [COL_W-1:0] cur_col_q;
  logic [DQ_W-1:0]  cur_wdata_q;
  logic [LANES-1:0] cas_low;
  logic [DQ_W-1:0]  rd_masked;
  logic             rsp_valid_q;
  logic [DQ_W-1:0]  rsp_rdata_q;
  logic             capture;

  edo_wait_timer #(.W(TMR_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .done_o(tmr_done)
  );

  edo_ras_age #(.LIMIT(T_RASP_MAX), .W(AGE_W)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_low_i(ras_low), .age_o(age_q)
  );

  edo_row_tracker #(.ROW_W(ROW_W)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .open_i(open_row), .close_i(close_row),
    .row_i(req_addr_i[ADDR_W-1:COL_W]), .req_row_i(req_addr_i[ADDR_W-1:COL_W]),
    .row_o(open_row_q), .hit_o(row_hit)
  );

  assign timeout   = age_q > HIT_AGE;
  assign can_close = age_q >= MIN_AGE;

  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    open_row  = 1'b0;
    close_row = 1'b0;
    ref_done  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_req_i) state_d = S_REF_CSR;
        else if (req_valid_i) begin
          accept = 1'b1; open_row = 1'b1; state_d = S_ROWSET;
        end
      end
      S_ROWSET:   state_d = S_ACT;
      S_ACT:      if (tmr_done) state_d = S_COL;
      S_COL:      state_d = S_CAS_LO;
      S_CAS_LO:   if (tmr_done) state_d = S_CAS_HI;
      S_CAS_HI:   if (tmr_done) state_d = S_OPEN;
      S_OPEN: begin
        if (ref_req_i || timeout || (req_valid_i && !row_hit)) begin
          if (can_close) begin close_row = 1'b1; state_d = S_PRE; end
        end else if (req_valid_i) begin
          accept = 1'b1; state_d = S_COL;
        end
      end
      S_PRE:      if (tmr_done) state_d = S_IDLE;
      S_REF_CSR:  if (tmr_done) state_d = S_REF_RAS;
      S_REF_RAS:  if (tmr_done) state_d = S_REF_HOLD;
      S_REF_HOLD: if (can_close) begin ref_done = 1'b1; state_d = S_PRE; end
      default:    state_d = S_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      S_ACT:     tmr_val = TMR_W'(T_RCD - 1);
      S_CAS_LO:  tmr_val = TMR_W'(T_CAS - 1);
      S_CAS_HI:  tmr_val = TMR_W'(T_CP - 1);
      S_PRE:     tmr_val = TMR_W'(T_RP - 1);
      S_REF_CSR: tmr_val = TMR_W'(T_CSR - 1);
      S_REF_RAS: tmr_val = TMR_W'(T_CHR - 1);
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cur_we_q    <= 1'b0;
      cur_be_q    <= '0;
      cur_col_q   <= '0;
      cur_wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_we_q    <= req_we_i;
        cur_be_q    <= req_be_i;
        cur_col_q   <= req_addr_i[COL_W-1:0];
        cur_wdata_q <= req_wdata_i;
      end
    end
  end

  assign req_ready_o = !ref_req_i &&
                       ((state_q == S_IDLE) || ((state_q == S_OPEN) && !timeout && row_hit));
  assign ref_done_o  = ref_done;

  assign ras_low = (state_q == S_ACT) || (state_q == S_COL) || (state_q == S_CAS_LO) ||
                   (state_q == S_CAS_HI) || (state_q == S_OPEN) ||
                   (state_q == S_REF_RAS) || (state_q == S_REF_HOLD);

  // lane 0 = lower byte, lane 1 = upper byte; both fall together in refresh
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_low[g] = ((state_q == S_CAS_LO) && cur_be_q[g]) ||
                        (state_q == S_REF_CSR) || (state_q == S_REF_RAS);
    assign rd_masked[g*LANE_W +: LANE_W] = cur_be_q[g] ? dram_dq_i[g*LANE_W +: LANE_W] : '0;
  end

  assign dram_ras_no  = !ras_low;
  assign dram_lcas_no = !cas_low[0];
  assign dram_ucas_no = !cas_low[1];
  assign dram_we_no   = !(cur_we_q && ((state_q == S_COL) || (state_q == S_CAS_LO)));
  assign dram_oe_no   = !(!cur_we_q && ((state_q == S_COL) || (state_q == S_CAS_LO)));
  assign dram_dq_oe_o = !dram_we_no;
  assign dram_dq_o    = cur_wdata_q;

  always_comb begin
    unique case (state_q)
      S_COL, S_CAS_LO, S_CAS_HI: dram_addr_o = ROW_W'(cur_col_q);
      default:                   dram_addr_o = open_row_q;
    endcase
  end

  assign capture = (state_q == S_CAS_LO) && tmr_done && !cur_we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= capture;
      if (capture) rsp_rdata_q <= rd_masked;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_EARLY_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($fell(dram_ucas_no) || $fell(dram_lcas_no)) && !dram_we_no) |-> $past(!dram_we_no)); // R4
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> dram_oe_no); // R4
  AST_RAS_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |-> ($past(age_q) >= MIN_AGE)); // R2
  AST_RAS_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_ras_no |-> (age_q < AGE_W'(T_RASP_MAX))); // R3
  AST_CAS_SKEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_ucas_no && !dram_lcas_no) |->
      (($fell(dram_ucas_no) == $fell(dram_lcas_no)) || $past(!dram_ucas_no && !dram_lcas_no))); // R7
  AST_REF_WE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_ras_no && (!dram_ucas_no || !dram_lcas_no)) |-> dram_we_no); // R6
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R9
endmodule

// File: tb/edo_page_seq_tb.sv
`timescale 1ns/100ps
module edo_page_seq_tb;
  localparam int ROW_W = 13, COL_W = 9, DQ_W = 16;
  localparam int T_RP = 8, T_RAS_MIN = 13, T_RCD = 3, T_CAS = 2, T_CP = 2;
  localparam int T_CSR = 2, T_CHR = 2, T_RASP = 60;
  localparam int PAGE_LEN = 1 + T_CAS + T_CP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [DQ_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ref_done;
  logic [DQ_W-1:0] rsp_rdata, dq_o, dq_i;
  logic ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
  logic [ROW_W-1:0] dram_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  edo_page_seq #(.T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RASP_MAX(T_RASP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .ref_req_i(ref_req),
    .ref_done_o(ref_done), .dram_ras_no(ras_n), .dram_ucas_no(ucas_n),
    .dram_lcas_no(lcas_n), .dram_we_no(we_n), .dram_oe_no(oe_n), .dram_addr_o(dram_addr),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i));

  // memory model and pin monitor
  logic [15:0] mem [int unsigned];
  logic [15:0] rd_word = '0;
  logic [ROW_W-1:0] m_row = '0;
  logic p_ras = 1, p_u = 1, p_l = 1, p_we = 1;
  int ras_lo_len = 0, ras_hi_len = 0, last_ras_lo = 0, ras_falls = 0, refs = 0;
  int cbr_len = 0, chr_len = 0;
  bit had_rise = 0, in_ref = 0;
  int e_rp = 0, e_rmin = 0, e_rmax = 0, e_early = 0, e_weoe = 0, e_skew = 0, e_cbr = 0;

  assign dq_i = !oe_n ? rd_word : '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic fu, fl;
      int unsigned key;
      logic [15:0] w;
      fu = !ucas_n && p_u;
      fl = !lcas_n && p_l;
      if (!ras_n && p_ras) begin
        ras_falls++;
        m_row = dram_addr;
        if (had_rise && ras_hi_len < T_RP) e_rp++;
        if (!ucas_n && !lcas_n) begin
          refs++; in_ref = 1; chr_len = 0;
          if (cbr_len < T_CSR || !we_n) e_cbr++;
        end
        ras_hi_len = 0;
      end
      if (ras_n && !p_ras) begin
        last_ras_lo = ras_lo_len;
        if (ras_lo_len < T_RAS_MIN) e_rmin++;
        ras_lo_len = 0; had_rise = 1;
      end
      if (in_ref) begin
        if (!ucas_n && !lcas_n && !ras_n) chr_len++;
        else begin
          if (chr_len < T_CHR) e_cbr++;
          in_ref = 0;
        end
      end
      if (ras_n && (!ucas_n || !lcas_n)) cbr_len++; else cbr_len = 0;
      if (!ras_n) ras_lo_len++; else ras_hi_len++;
      if (ras_lo_len > T_RASP) e_rmax++;
      if ((fu || fl) && !ras_n && !we_n && p_we) e_early++;
      if ((fu != fl) && !ucas_n && !lcas_n) e_skew++;
      if (!we_n && !oe_n) e_weoe++;
      if ((fu || fl) && !ras_n) begin
        key = {10'd0, m_row, dram_addr[COL_W-1:0]};
        rd_word = mem.exists(key) ? mem[key] : 16'h0;
        if (!we_n) begin
          w = rd_word;
          if (fl) w[7:0] = dq_o[7:0];
          if (fu) w[15:8] = dq_o[15:8];
          mem[key] = w;
        end
      end
      p_ras = ras_n; p_u = ucas_n; p_l = lcas_n; p_we = we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input int row, input int col);
    return {ROW_W'(row), COL_W'(col)};
  endfunction

  task automatic host_op(input logic we, input logic [21:0] a, input logic [1:0] be,
                         input logic [15:0] wd, output logic [15:0] rd);
    bit was_low, now_low;
    rd = '0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!we) begin
      was_low = 0;
      for (int i = 0; i < 100; i++) begin
        now_low = !ucas_n || !lcas_n;
        if (rsp_valid) begin
          // R9: pulse lands in the first cycle after the column strobe rises
          chk(!now_low && was_low, "R9 rsp timing", {now_low, was_low}, 2'b01);
          rd = rsp_rdata;
          break;
        end
        was_low = now_low;
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({ras_n, ucas_n, lcas_n, we_n, oe_n} == 5'h1f, "R8 strobes", {ras_n, ucas_n, lcas_n, we_n, oe_n}, 5'h1f);
    chk(req_ready == 1'b1, "R8 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R8 rsp", rsp_valid, 0);
  endtask

  task automatic t_page_hit;
    logic [15:0] rd;
    int f0;
    f0 = ras_falls;
    host_op(1, mk(5, 3), 2'b11, 16'h1234, rd);
    host_op(1, mk(5, 4), 2'b11, 16'hABCD, rd);
    host_op(0, mk(5, 3), 2'b11, 16'h0, rd);
    chk(rd == 16'h1234, "R1 read hit", rd, 16'h1234);
    host_op(0, mk(5, 4), 2'b11, 16'h0, rd);
    chk(rd == 16'hABCD, "R10 column select", rd, 16'hABCD);
    chk(ras_falls - f0 == 1, "R1 single row open", ras_falls - f0, 1);
  endtask

  task automatic t_row_miss;
    logic [15:0] rd;
    int f0;
    f0 = ras_falls;
    host_op(1, mk(9, 3), 2'b11, 16'h5555, rd);
    host_op(0, mk(5, 3), 2'b11, 16'h0, rd);
    chk(rd == 16'h1234, "R10 row select", rd, 16'h1234);
    host_op(0, mk(9, 3), 2'b11, 16'h0, rd);
    chk(rd == 16'h5555, "R2 reopen data", rd, 16'h5555);
    chk(ras_falls - f0 == 3, "R2 miss reopens", ras_falls - f0, 3);
  endtask

  task automatic t_byte_mask;
    logic [15:0] rd;
    host_op(1, mk(5, 3), 2'b01, 16'hEEFF, rd);
    host_op(0, mk(5, 3), 2'b11, 16'h0, rd);
    chk(rd == 16'h12FF, "R5 lower only written", rd, 16'h12FF);
    host_op(0, mk(5, 3), 2'b10, 16'h0, rd);
    chk(rd == 16'h1200, "R5 masked lower reads zero", rd, 16'h1200);
    host_op(0, mk(5, 3), 2'b01, 16'h0, rd);
    chk(rd == 16'h00FF, "R5 masked upper reads zero", rd, 16'h00FF);
  endtask

  task automatic t_ref_collide;
    logic [15:0] rd;
    int f0, r0;
    bit early;
    host_op(1, mk(5, 7), 2'b11, 16'h0F0F, rd);
    f0 = ras_falls; r0 = refs; early = 0;
    fork
      host_op(0, mk(5, 7), 2'b11, 16'h0, rd);
      begin
        @(negedge clk);
        ref_req = 1;
        do begin
          @(negedge clk);
          #1;
          if (req_valid && req_ready && !ref_done) early = 1;
        end while (!ref_done);
        ref_req = 0;
      end
    join
    chk(!early, "R6 refresh wins", early, 0);
    chk(refs - r0 == 1, "R6 one refresh", refs - r0, 1);
    chk(ras_falls - f0 == 2, "R6 row closed and reopened", ras_falls - f0, 2);
    chk(rd == 16'h0F0F, "R6 data after refresh", rd, 16'h0F0F);
  endtask

  task automatic t_timeout;
    logic [15:0] rd;
    host_op(1, mk(7, 1), 2'b11, 16'h7777, rd);
    repeat (T_RASP + 20) @(negedge clk);
    chk(ras_n == 1'b1, "R3 row closed when idle", ras_n, 1);
    chk(last_ras_lo == T_RASP - PAGE_LEN, "R3 timeout length", last_ras_lo, T_RASP - PAGE_LEN);
    host_op(0, mk(7, 1), 2'b11, 16'h0, rd);
    chk(rd == 16'h7777, "R3 data after timeout", rd, 16'h7777);
  endtask

  task automatic t_monitors;
    chk(e_rp == 0, "R2 precharge", e_rp, 0);
    chk(e_rmin == 0, "R2 ras min", e_rmin, 0);
    chk(e_rmax == 0, "R3 ras max", e_rmax, 0);
    chk(e_early == 0, "R4 early write", e_early, 0);
    chk(e_weoe == 0, "R4 oe during write", e_weoe, 0);
    chk(e_skew == 0, "R7 cas skew", e_skew, 0);
    chk(e_cbr == 0, "R6 cbr setup hold", e_cbr, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_page_hit();
    t_row_miss();
    t_byte_mask();
    t_ref_collide();
    t_timeout();
    repeat (5) @(negedge clk);
    t_monitors();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule